// File: doc/BRIEF.md
# Multiplexed-Bus Page-Write Nonvolatile Memory

This block models a byte-wide nonvolatile memory that a microcontroller reaches over a shared address/data bus. The host presents the low address byte on the shared bus and the upper address bits on dedicated pins while the address strobe is high. The latch is transparent while the strobe is high and holds the full address from the strobe's falling edge. After that, the shared bus carries data. Its direction comes from the read/write line, qualified by the E clock, a select input and a pair of chip enables. One enable is active low and the other active high.

Writes collect into a page buffer, and every byte in the buffer belongs to one page. Each accepted byte restarts a window timer. When the window expires, the buffered page goes through a timed internal write cycle and is then copied into the array. While that cycle runs, reads return a status byte in which one bit inverts on every read. The host can therefore detect the end of the write early by polling until that bit stops toggling. The shared bus is modelled as separate input, output and output-enable signals. The array defaults to 2048 bytes, and the address width is a parameter.

Top module: `mux_eeprom_ctl`

## Requirements
- R1: The byte address is `{ahi_i, ad_i}`, with the upper bits on `ahi_i` and the low 8 bits on the shared bus. A read returns the byte stored at that address.
- R2: While `as_i` is high the address follows the pins. Once `as_i` is low the last address seen with the strobe high is held, and later changes on `ad_i` or `ahi_i` do not alter it.
- R3: `ad_oe` is high only when `e_i`=1, `rw_i`=1, `as_i`=0, `ce_n_i`=0, `ce_i`=1 and `sel_i`=0. Clearing any one enable or setting `sel_i` stops the drive.
- R4: When `ce_n_i` is high and `as_i` is low the block is in standby. It does not drive the bus and it accepts no write.
- R5: A write is sampled on the falling edge of `e_i`, with `rw_i`=0, the enables asserted and `as_i` low. The byte goes into the page buffer and reaches the array only after the internal write cycle. After reset every array byte reads 0xFF.
- R6: The first buffered byte fixes the page, which is address bits [ADDR_W-1:PAGE_W]. A later byte whose page bits differ is dropped.
- R7: Each accepted byte restarts a window of WIN_CYC clocks. When no byte arrives within the window, the internal write cycle starts. Until then, reads return the old array contents.
- R8: The internal write cycle lasts WR_CYC clocks. Write attempts during it are ignored.
- R9: A read during the internal write cycle returns a status byte. Bit 6 of that byte is 0 on the first read and inverts after every completed read. All other bits read 0. After the cycle ends, reads return the array data.
- R10: After reset the block is idle, `ad_oe` is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples all bus inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| as_i | input | 1 | Address strobe; the latch is transparent while it is high |
| ad_i | input | 8 | Shared bus in: low address byte, then write data |
| ad_o | output | 8 | Shared bus out: read data or status byte |
| ad_oe | output | 1 | High when the block drives the shared bus |
| ahi_i | input | ADDR_W-8 | Upper address bits |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| sel_i | input | 1 | Select; held low for multiplexed-bus operation |
| rw_i | input | 1 | 1 = read, 0 = write |
| e_i | input | 1 | E-clock qualifier; a write is sampled on its falling edge |

## Verification
The following properties are checked on every cycle:
- The bus is never driven in standby.
- The latched address stays put while the strobe is low.
- The page tag does not move while bytes are being buffered.
- The window counter stays within its bound.
- Every internal write cycle lasts exactly WR_CYC clocks.
- The buffer is frozen against writes while the cycle runs.
- The status bit moves only on a completed read.

Some behaviours only the bench scenarios can show. These are the actual byte values that land in the array, the dropping of bytes from a foreign page or from a disabled or busy cycle, and the toggle sequence 0x00, 0x40, 0x00 as the host sees it. The bench also shows that old data remains visible while the window is still open.

// File: rtl/mux_eeprom_ctl.sv
module mux_eeprom_ctl #(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 7,
  parameter int WIN_CYC = 16,
  parameter int WR_CYC  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic [7:0]        ad_i,
  output logic [7:0]        ad_o,
  output logic              ad_oe,
  input  logic [ADDR_W-9:0] ahi_i,
  input  logic              ce_n_i,
  input  logic              ce_i,
  input  logic              sel_i,
  input  logic              rw_i,
  input  logic              e_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TAG_W = ADDR_W - PAGE_W;
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam int WR_W  = $clog2(WR_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_BUSY} st_t;

  st_t               st;
  logic [7:0]        mem   [DEPTH];
  logic [7:0]        buf_d [PAGE];
  logic [PAGE-1:0]   buf_v;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q, addr;
  logic [WIN_W-1:0]  win;
  logic [WR_W-1:0]   wr;
  logic              e_q, tog;

  assign addr = as_i ? {ahi_i, ad_i} : addr_q;

  wire              sel_ok  = !ce_n_i && ce_i && !sel_i;
  wire              dphase  = sel_ok && !as_i;
  wire              e_fall  = e_q && !e_i;
  wire              wr_hit  = dphase && !rw_i && e_fall;
  wire              rd_end  = dphase && rw_i && e_fall;
  wire [TAG_W-1:0]  tag     = addr[ADDR_W-1:PAGE_W];
  wire [PAGE_W-1:0] pg      = addr[PAGE_W-1:0];
  wire              accept  = wr_hit && (st == ST_IDLE || (st == ST_LOAD && tag == tag_q));
  wire              commit  = (st == ST_BUSY) && (wr == '0);

  assign ad_oe = dphase && rw_i && e_i;
  assign ad_o  = (st == ST_BUSY) ? {1'b0, tog, 6'b0} : mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      e_q    <= 1'b0;
    end else begin
      if (as_i) addr_q <= {ahi_i, ad_i};
      e_q <= e_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tag_q <= '0;
      buf_v <= '0;
      win   <= '0;
      wr    <= '0;
      tog   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          tag_q <= tag;
          buf_v <= {{(PAGE-1){1'b0}}, 1'b1} << pg;
          win   <= WIN_W'(WIN_CYC - 1);
          st    <= ST_LOAD;
        end
        ST_LOAD: if (accept) begin
          buf_v[pg] <= 1'b1;
          win       <= WIN_W'(WIN_CYC - 1);
        end else if (win == '0) begin
          wr  <= WR_W'(WR_CYC - 1);
          tog <= 1'b0;
          st  <= ST_BUSY;
        end else begin
          win <= win - 1'b1;
        end
        ST_BUSY: begin
          if (rd_end) tog <= ~tog;
          if (wr == '0) begin
            buf_v <= '0;
            st    <= ST_IDLE;
          end else begin
            wr <= wr - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) buf_d[pg] <= ad_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (buf_v[i]) mem[{tag_q, PAGE_W'(i)}] <= buf_d[i];
    end
  end

  logic [WR_W:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)              busy_run <= '0;
    else if (st == ST_BUSY)  busy_run <= busy_run + 1'b1;
    else                     busy_run <= '0;
  end

  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i && !as_i) |-> !ad_oe);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_i && $past(!as_i)) |-> $stable(addr_q));

  // R6
  tag_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD && $past(st) == ST_LOAD) |-> $stable(tag_q));

  // R7
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD) |-> (32'(win) < WIN_CYC));

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st == ST_BUSY) |-> (32'(busy_run) == WR_CYC));

  // R8
  busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && wr != '0) |=> $stable(buf_v));

  // R9
  tog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && $past(st) == ST_BUSY && !$past(rd_end)) |-> $stable(tog));
endmodule

// File: tb/tb_mux_eeprom_ctl.sv
module tb_mux_eeprom_ctl;
  localparam int ADDR_W  = 11;
  localparam int WIN_CYC = 16;
  localparam int WR_CYC  = 200;

  typedef struct {bit oe; logic [7:0] d; string rq;} item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic as_i = 1'b0, ce_n_i = 1'b0, ce_i = 1'b1, sel_i = 1'b0, rw_i = 1'b1, e_i = 1'b0;
  logic [7:0] ad_i = '0;
  logic [ADDR_W-9:0] ahi_i = '0;
  logic [7:0] ad_o;
  logic ad_oe;
  logic want = 1'b0;
  int checks = 0, errors = 0;
  item_t exp_q[$];

  always #5 clk = ~clk;

  mux_eeprom_ctl #(.ADDR_W(ADDR_W), .PAGE_W(7), .WIN_CYC(WIN_CYC), .WR_CYC(WR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .ahi_i(ahi_i), .ce_n_i(ce_n_i), .ce_i(ce_i), .sel_i(sel_i), .rw_i(rw_i), .e_i(e_i));

  always @(negedge clk) begin
    if (want) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL monitor: sample with empty queue, act oe=%0b data=%02h exp none", ad_oe, ad_o);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (ad_oe !== it.oe || (it.oe && ad_o !== it.d)) begin
          errors++;
          $display("FAIL %s: act oe=%0b data=%02h exp oe=%0b data=%02h", it.rq, ad_oe, ad_o, it.oe, it.d);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %02h exp %02h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input bit eoe, input logic [7:0] ed, input string rq);
    exp_q.push_back('{eoe, ed, rq});
    tick(1); as_i = 1'b1; ad_i = a[7:0]; ahi_i = a[ADDR_W-1:8]; rw_i = 1'b1; e_i = 1'b0;
    tick(1); as_i = 1'b0; ad_i = 8'h5A; ahi_i = ~ahi_i;
    tick(1); e_i = 1'b1;
    tick(1); want = 1'b1;
    tick(1); want = 1'b0; e_i = 1'b0;
    tick(1);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    tick(1); as_i = 1'b1; ad_i = a[7:0]; ahi_i = a[ADDR_W-1:8]; rw_i = 1'b1; e_i = 1'b0;
    tick(1); as_i = 1'b0; rw_i = 1'b0; ad_i = d;
    tick(1); e_i = 1'b1;
    tick(1); e_i = 1'b0;
    tick(1); rw_i = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    chk(ad_oe === 1'b0, "R10 oe after reset", {7'b0, ad_oe}, 8'h00);
    rd(11'h123, 1, 8'hFF, "R10 erased after reset");

    // R5 / R7 single byte, visible only after the write cycle
    wr(11'h123, 8'hA5);
    rd(11'h123, 1, 8'hFF, "R7 old data inside window");
    tick(14);
    // R9 toggle sequence
    rd(11'h123, 1, 8'h00, "R9 first status read");
    rd(11'h123, 1, 8'h40, "R9 second status read");
    rd(11'h123, 1, 8'h00, "R9 third status read");
    tick(WR_CYC);
    rd(11'h123, 1, 8'hA5, "R5 committed byte");
    rd(11'h124, 1, 8'hFF, "R5 neighbour untouched");

    // R6 page rules, R8 busy ignores writes
    wr(11'h200, 8'h11);
    wr(11'h27F, 8'h22);
    wr(11'h280, 8'h33);
    wr(11'h240, 8'h44);
    tick(WIN_CYC + 4);
    wr(11'h300, 8'h55);
    tick(WR_CYC + 20);
    rd(11'h200, 1, 8'h11, "R5 page byte 0");
    rd(11'h27F, 1, 8'h22, "R2 page last byte with scrambled bus");
    rd(11'h240, 1, 8'h44, "R1 high address bits select byte");
    rd(11'h040, 1, 8'hFF, "R1 other high bits");
    rd(11'h280, 1, 8'hFF, "R6 foreign page dropped");
    rd(11'h300, 1, 8'hFF, "R8 write during cycle ignored");

    // R3 drive qualifiers
    ce_i = 1'b0;
    rd(11'h200, 0, 8'h00, "R3 active-high enable low");
    ce_i = 1'b1; sel_i = 1'b1;
    rd(11'h200, 0, 8'h00, "R3 select high");
    sel_i = 1'b0; ce_n_i = 1'b1;
    rd(11'h200, 0, 8'h00, "R4 standby no drive");
    // R3 no drive with E low during data phase
    tick(1); as_i = 1'b0; rw_i = 1'b1; e_i = 1'b0; ce_n_i = 1'b0;
    tick(1);
    chk(ad_oe === 1'b0, "R3 E low no drive", {7'b0, ad_oe}, 8'h00);
    // R4 write in standby ignored
    ce_n_i = 1'b1;
    wr(11'h201, 8'h77);
    ce_n_i = 1'b0;
    tick(WIN_CYC + WR_CYC + 10);
    rd(11'h201, 1, 8'hFF, "R4 standby write ignored");
    rd(11'h200, 1, 8'h11, "R5 data retained");

    tick(3);
    chk(exp_q.size() == 0, "R9 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule